// File: doc/BRIEF.md
# Two-Clock Period Comparator

This block takes two free-running square waves that are asynchronous to each other and to the system clock. Their rates are close, and their phase offset can be anything. The block decides, continuously, whether the first wave's period is the same as, shorter than, or longer than the second wave's period. Both inputs are sampled by a much faster system clock. Each input is synchronised, and its rising edges are found. The number of system clocks between consecutive rising edges of an input is that input's period.

The two latest periods are compared every cycle, and the result goes to three registered flags. When the two counts differ by no more than a small tolerance, they are reported as equal. This absorbs the one-clock uncertainty that synchronising an asynchronous edge adds. The flags stay low until both inputs have produced one full period after reset. If an input stops toggling, its running count holds at its ceiling, so a stalled input looks very slow rather than aliasing to a short period.

Top module: `period_compare`

## Requirements
- R1: While `rst` is high, and on the first sampling after its release, all three flags are low.
- R2: Each raw input passes through a chain of SYNC_STAGES flops (default 2) before its rising edge is detected. After a raw rising edge, the flags reflect the new period at the fourth rising clock edge, and not earlier.
- R3: An input's period is the number of system clock cycles from one detected rising edge to the next. The running counter holds 1 in the cycle after each detected edge.
- R4: All flags stay low until both inputs have each completed at least one period after reset, which takes two detected rising edges per input.
- R5: `p_eq_q` is high when the absolute difference of the two latched periods is at most TOL (default 1). For example, periods 20 and 21 give equal.
- R6: `p_lt_q` is high when the P period is smaller than the Q period by more than TOL.
- R7: `p_gt_q` is high when the P period is larger than the Q period by more than TOL.
- R8: At most one flag is high at any time. Exactly one is high in every cycle once both periods are valid.
- R9: A period counter stops at 2^CNT_W-1 instead of wrapping. That value is latched as the period at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| p_clk_in | input | 1 | Raw asynchronous square wave P |
| q_clk_in | input | 1 | Raw asynchronous square wave Q |
| p_eq_q | output | 1 | Periods equal within TOL |
| p_lt_q | output | 1 | P period shorter than Q period |
| p_gt_q | output | 1 | P period longer than Q period |

## Verification
The tolerance band gets directed pairs one count apart and two counts apart. A comparator that used the wrong bound would call a one-count difference unequal, or call a two-count difference equal. The start-up window runs P alone while Q is held still. A design that reported before both periods were complete would raise a flag from a zero or partial count. The stall case holds one input low long enough that a wrapping counter would land on a value that compares equal, so the flags would show equal instead of shorter. The same case also samples the flags one cycle before and in the cycle of the expected update, which catches a synchronizer that is one flop short or one flop long.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // Bit positions of the packed result {gt, lt, eq}
  localparam int FLAG_EQ = 0;
  localparam int FLAG_LT = 1;
  localparam int FLAG_GT = 2;
  localparam int N_FLAGS = 3;
  localparam int N_CH    = 2;   // channel 0 = P, channel 1 = Q

  typedef logic [N_FLAGS-1:0] cmp_flags_t;
endpackage

// File: rtl/pc_sync_edge.sv
module pc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pc_period_meter.sv
module pc_period_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      period <= '0;
      armed  <= 1'b0;
      valid  <= 1'b0;
    end else if (rise) begin
      count <= CNT_W'(1);
      armed <= 1'b1;
      if (armed) begin
        period <= count;
        valid  <= 1'b1;
      end
    end else if (count != CNT_MAX) begin
      count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/period_compare.sv
module period_compare #(
  parameter int CNT_W       = 16,
  parameter int TOL         = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic p_clk_in,
  input  logic q_clk_in,
  output logic p_eq_q,
  output logic p_lt_q,
  output logic p_gt_q
);
  import pc_pkg::*;

  logic [N_CH-1:0] raw_in;
  logic [N_CH-1:0] rise_ch;
  logic [N_CH-1:0] valid_ch;
  logic [CNT_W-1:0] period_ch [N_CH];
  logic [CNT_W-1:0] count_ch  [N_CH];

  assign raw_in = {q_clk_in, p_clk_in};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pc_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .din (raw_in[ch]),
      .rise(rise_ch[ch])
    );
    pc_period_meter #(.CNT_W(CNT_W)) meter_i (
      .clk   (clk),
      .rst   (rst),
      .rise  (rise_ch[ch]),
      .period(period_ch[ch]),
      .count (count_ch[ch]),
      .valid (valid_ch[ch])
    );
  end

  // Named views for the bound checker
  logic [CNT_W-1:0] cnt_p, cnt_q;
  logic             rise_p, rise_q, vld_both;
  assign cnt_p    = count_ch[0];
  assign cnt_q    = count_ch[1];
  assign rise_p   = rise_ch[0];
  assign rise_q   = rise_ch[1];
  assign vld_both = &valid_ch;

  // Three-way compare with tolerance band
  logic [CNT_W-1:0] abs_diff;
  logic             p_smaller;
  cmp_flags_t       cmp_next;

  always_comb begin
    p_smaller = period_ch[0] < period_ch[1];
    abs_diff  = p_smaller ? (period_ch[1] - period_ch[0])
                          : (period_ch[0] - period_ch[1]);
    cmp_next  = '0;
    if (32'(abs_diff) <= TOL) cmp_next[FLAG_EQ] = 1'b1;
    else if (p_smaller)       cmp_next[FLAG_LT] = 1'b1;
    else                      cmp_next[FLAG_GT] = 1'b1;
  end

  cmp_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (rst)           flags_q <= '0;
    else if (vld_both) flags_q <= cmp_next;
    else               flags_q <= '0;
  end

  assign p_eq_q = flags_q[FLAG_EQ];
  assign p_lt_q = flags_q[FLAG_LT];
  assign p_gt_q = flags_q[FLAG_GT];
endmodule

// File: rtl/period_compare_chk.sv
module period_compare_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             p_eq_q,
  input logic             p_lt_q,
  input logic             p_gt_q,
  input logic             vld_both,
  input logic             rise_p,
  input logic             rise_q,
  input logic [CNT_W-1:0] cnt_p,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({p_gt_q, p_lt_q, p_eq_q}));

  assert_one_flag_valid_R8: assert property (@(posedge clk) disable iff (rst)
    $past(vld_both) |-> $onehot({p_gt_q, p_lt_q, p_eq_q}));

  assert_quiet_until_valid_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(vld_both) |-> ({p_gt_q, p_lt_q, p_eq_q} == 3'b000));

  assert_restart_p_R3: assert property (@(posedge clk) disable iff (rst)
    rise_p |=> cnt_p == CNT_W'(1));

  assert_restart_q_R3: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> cnt_q == CNT_W'(1));

  assert_saturate_p_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_p == CNT_MAX && !rise_p) |=> cnt_p == CNT_MAX);

  assert_saturate_q_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !rise_q) |=> cnt_q == CNT_MAX);
endmodule

bind period_compare period_compare_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .p_eq_q  (p_eq_q),
  .p_lt_q  (p_lt_q),
  .p_gt_q  (p_gt_q),
  .vld_both(vld_both),
  .rise_p  (rise_p),
  .rise_q  (rise_q),
  .cnt_p   (cnt_p),
  .cnt_q   (cnt_q)
);

// File: tb/period_compare_tb_top.sv
module period_compare_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_raw = 1'b0, q_raw = 1'b0;
  logic p2_raw = 1'b0, q2_raw = 1'b0;
  logic eq, lt, gt, eq2, lt2, gt2;

  int n_checks = 0;
  int n_fail   = 0;
  bit sat_done = 1'b0;

  int p_hi = 10, p_lo = 10, q_hi = 10, q_lo = 10;
  bit p_run = 1'b0, q_run = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  period_compare dut_i (
    .clk(clk), .rst(rst), .p_clk_in(p_raw), .q_clk_in(q_raw),
    .p_eq_q(eq), .p_lt_q(lt), .p_gt_q(gt)
  );

  period_compare #(.CNT_W(6)) dut_sat_i (
    .clk(clk), .rst(rst), .p_clk_in(p2_raw), .q_clk_in(q2_raw),
    .p_eq_q(eq2), .p_lt_q(lt2), .p_gt_q(gt2)
  );

  // Expected {gt, lt, eq} from the requirements, tolerance 1
  function automatic logic [2:0] exp_flags(int pp, int qp);
    int d;
    d = (pp > qp) ? pp - qp : qp - pp;
    if (d <= 1)       return 3'b001;
    else if (pp < qp) return 3'b010;
    else              return 3'b100;
  endfunction

  task automatic check3(logic [2:0] act, logic [2:0] exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flags {gt,lt,eq} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Wave generators, changed on falling edges
  initial forever begin
    if (!p_run) begin p_raw = 1'b0; @(negedge clk); end
    else begin
      p_raw = 1'b1; repeat (p_hi) @(negedge clk);
      p_raw = 1'b0; repeat (p_lo) @(negedge clk);
    end
  end

  initial forever begin
    if (!q_run) begin q_raw = 1'b0; @(negedge clk); end
    else begin
      q_raw = 1'b1; repeat (q_hi) @(negedge clk);
      q_raw = 1'b0; repeat (q_lo) @(negedge clk);
    end
  end

  initial forever begin
    @(negedge clk);
    if (!rst) begin
      p2_raw = 1'b1; repeat (5) @(negedge clk);
      p2_raw = 1'b0; repeat (4) @(negedge clk);
    end
  end

  task automatic run_pair(int ph, int pl, int qh, int ql, string req);
    int mx;
    p_hi = ph; p_lo = pl; q_hi = qh; q_lo = ql;
    mx = (ph + pl > qh + ql) ? ph + pl : qh + ql;
    repeat (3 * mx + 12) @(negedge clk);
    check3({gt, lt, eq}, exp_flags(ph + pl, qh + ql), req);
  endtask

  // Stall case on the narrow instance: a 6-bit counter wrapping at 138 would give 10
  initial begin
    @(negedge clk);
    while (rst) @(negedge clk);
    repeat (8) begin
      q2_raw = 1'b1; repeat (5) @(negedge clk);
      q2_raw = 1'b0; repeat (5) @(negedge clk);
    end
    q2_raw = 1'b1; repeat (5) @(negedge clk);
    q2_raw = 1'b0; repeat (133) @(negedge clk);
    q2_raw = 1'b1;
    repeat (3) @(negedge clk);
    check3({gt2, lt2, eq2}, 3'b001, "R2 no update before 4th edge");
    @(negedge clk);
    check3({gt2, lt2, eq2}, 3'b010, "R9 saturated period, R2 update on 4th edge");
    repeat (2) @(negedge clk);
    q2_raw = 1'b0;
    sat_done = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check3({gt, lt, eq}, 3'b000, "R1 during reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check3({gt, lt, eq}, 3'b000, "R1 after release");

    p_run = 1'b1;
    repeat (150) @(negedge clk);
    check3({gt, lt, eq}, 3'b000, "R4 only P toggling");
    q_run = 1'b1;
    q_raw = 1'b0;
    repeat (24) @(negedge clk);
    check3({gt, lt, eq}, 3'b000, "R4 Q not yet complete");

    run_pair(10, 10, 10, 10, "R5 equal periods 20/20, R3");
    run_pair(10, 10, 10, 11, "R5 within tolerance 20/21");
    run_pair(10, 11, 10, 10, "R5 within tolerance 21/20");
    run_pair(10, 10, 11, 11, "R6 P shorter by 2");
    run_pair(12, 12, 10, 10, "R7 P longer by 4");
    run_pair(6, 6, 30, 30, "R6 wide gap");
    run_pair(30, 30, 6, 6, "R7 wide gap");

    for (int i = 0; i < 12; i++) begin
      int a, b, c, d;
      a = 6 + int'($urandom_range(24));
      b = a + int'($urandom_range(1));
      c = 6 + int'($urandom_range(24));
      d = c + int'($urandom_range(1));
      run_pair(a, b, c, d, "R8 random pair");
      n_checks++;
      if ($countones({gt, lt, eq}) != 1) begin
        n_fail++;
        $display("FAIL R8: flag count actual %0d expected 1", $countones({gt, lt, eq}));
      end
    end

    while (!sat_done) @(negedge clk);
    report();
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule